// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Decoder with Refresh Row Counter

This block models the device side of an asynchronous DRAM. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable, together with the multiplexed address and the write data. Each strobe passes through a two-flop synchroniser. The relative order of strobe edges, judged on the synchronised samples, tells the block what each row-strobe-low period is. It can be a read, an early write, a delayed write or read-modify-write, a row-only refresh, a column-first refresh, a hidden refresh or a self-refresh.

A small parameterised array holds the data. The array is indexed by the low row bits latched at the row strobe fall and the low column bits latched at the column strobe fall. An internal refresh row counter, ADDR_W bits wide, supplies the row for column-first refreshes. When a row-strobe period ends, the block reports its class. Every refreshed row is announced with a one-cycle strobe. Strobe orders that match no defined cycle set a sticky error flag and leave the array untouched.

Top module: `dram_strobe_ctl`

## Requirements
- R1: After reset the following outputs are zero: `dq_oe`, `ref_cnt`, `proto_err`, `self_ref` and `cyc_kind`.
- R2: Read. The column strobe falls while the row strobe is low and write enable is high. The word at {row low bits, column low bits} is then driven on `dq_out` with `dq_oe`=1, for as long as the column strobe and output enable stay low. At the row strobe rise, `cyc_kind` becomes 1.
- R3: Early write. Write enable is low when the column strobe falls. The word on `dq_in` is then stored, `dq_oe` stays 0 for the whole cycle, and `cyc_kind` becomes 2.
- R4: Delayed write. Write enable falls while the column strobe is low in an access cycle. Until that point the outputs carry the old word, read as in R2. The `dq_in` word is then stored, and `cyc_kind` becomes 3.
- R5: Row-only refresh. The row strobe falls with the column strobe high, and the column strobe does not fall before the row strobe rises. At the rise, `rfsh_stb` pulses with `rfsh_row` equal to the latched row address. `ref_cnt` is unchanged and `cyc_kind` becomes 4.
- R6: Column-first refresh. The row strobe falls with the column strobe already low and write enable high. `rfsh_stb` then pulses with `rfsh_row` equal to the old `ref_cnt`, `ref_cnt` increments, and `cyc_kind` becomes 5.
- R7: Hidden refresh. After a read, the column strobe stays low while the row strobe rises and falls again. This refreshes as in R6 and sets `cyc_kind` to 6. The read word stays on `dq_out` with `dq_oe`=1 while output enable is low.
- R8: Self-refresh. In a refresh cycle the row strobe stays low for SR_TICKS clock ticks. `self_ref` then goes to 1 and stays there until the row strobe rises, after which it returns to 0 and `cyc_kind` becomes 7.
- R9: Protocol errors. Two strobe orders are errors: write enable low when the row strobe falls with the column strobe low, and a second column strobe fall inside a refresh cycle. Either one sets `proto_err`, which stays set until reset, and sets `cyc_kind` to 0. No array write takes place. The first error case does not advance `ref_cnt`. The second happens after the advance of R6 has already been made.
- R10: `dq_oe` drops to 0 when the column strobe rises or output enable is high.
- R11: `ref_cnt` wraps from 2^ADDR_W-1 to 0.
- R12: Page mode. Several column strobe pulses within one row-strobe-low period each access a new column of the same latched row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data, zero when not driven |
| dq_oe | output | 1 | Data output enable |
| ref_cnt | output | ADDR_W | Internal refresh row counter |
| rfsh_stb | output | 1 | One-cycle pulse per refreshed row |
| rfsh_row | output | ADDR_W | Row refreshed at the last `rfsh_stb` |
| self_ref | output | 1 | Self-refresh active |
| cyc_done | output | 1 | One-cycle pulse at each row strobe rise |
| cyc_kind | output | 3 | Class of the last completed row-strobe cycle |
| proto_err | output | 1 | Sticky strobe-order error |

## Verification
The bench builds the block with ADDR_W=11, DQ_W=4, a 4-by-4 array and SR_TICKS=40. With the small array, every word can be written with early writes and read back through page-mode reads. With the short self-refresh threshold, entry into self-refresh is reached in a few dozen ticks. The full 11-bit counter is kept, so 2048 back-to-back column-first refreshes drive the counter through its complete range and across the wrap, with the refreshed row checked at both ends.

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
  parameter int ADDR_W   = 11,
  parameter int DQ_W     = 4,
  parameter int AROW_W   = 2,
  parameter int ACOL_W   = 2,
  parameter int SR_TICKS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] ref_cnt,
  output logic              rfsh_stb,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic              self_ref,
  output logic              cyc_done,
  output logic [2:0]        cyc_kind,
  output logic              proto_err
);
  localparam int SW    = 4 + ADDR_W + DQ_W;
  localparam int IW    = AROW_W + ACOL_W;
  localparam int WORDS = 1 << IW;
  localparam int CNT_W = (SR_TICKS > 2) ? $clog2(SR_TICKS) : 1;
  localparam logic [SW-1:0] IDLE = {4'b1111, {(ADDR_W+DQ_W){1'b0}}};

  logic [SW-1:0] s1, s2;
  logic p_ras, p_cas, p_we;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= IDLE; s2 <= IDLE;
      p_ras <= 1'b1; p_cas <= 1'b1; p_we <= 1'b1;
    end else begin
      s1 <= {ras_n, cas_n, we_n, oe_n, addr, dq_in};
      s2 <= s1;
      p_ras <= s2[SW-1]; p_cas <= s2[SW-2]; p_we <= s2[SW-3];
    end

  wire              c_ras  = s2[SW-1];
  wire              c_cas  = s2[SW-2];
  wire              c_we   = s2[SW-3];
  wire              c_oe   = s2[SW-4];
  wire [ADDR_W-1:0] c_addr = s2[DQ_W +: ADDR_W];
  wire [DQ_W-1:0]   c_dq   = s2[DQ_W-1:0];

  wire ras_fall = p_ras & ~c_ras;
  wire ras_rise = ~p_ras & c_ras;
  wire cas_fall = p_cas & ~c_cas;
  wire cas_rise = ~p_cas & c_cas;
  wire we_fall  = p_we & ~c_we;

  logic in_cyc, refr, hid, err_cyc, cas_seen, hold_rd, rd_vld;
  logic [2:0]        acc_kind;
  logic [ADDR_W-1:0] row_q;
  logic [ACOL_W-1:0] col_q;
  logic [DQ_W-1:0]   rd_q;
  logic [CNT_W-1:0]  tcnt;
  logic [DQ_W-1:0]   mem [WORDS];

  wire acc       = in_cyc & ~refr & ~err_cyc;
  wire rd_ev     = acc & cas_fall & c_we;
  wire ew_ev     = acc & cas_fall & ~c_we;
  wire dw_ev     = acc & cas_seen & ~c_cas & we_fall & ~cas_fall;
  wire start_err = ras_fall & ~c_cas & ~c_we;
  wire refr_err  = in_cyc & refr & cas_fall;
  wire wen       = ew_ev | dw_ev;
  wire [IW-1:0] aidx = {row_q[AROW_W-1:0], c_addr[ACOL_W-1:0]};
  wire [IW-1:0] widx = ew_ev ? aidx : {row_q[AROW_W-1:0], col_q};

  always_ff @(posedge clk)
    if (wen) mem[widx] <= c_dq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_cyc <= 1'b0; refr <= 1'b0; hid <= 1'b0; err_cyc <= 1'b0;
      cas_seen <= 1'b0; hold_rd <= 1'b0; rd_vld <= 1'b0; self_ref <= 1'b0;
      acc_kind <= '0; row_q <= '0; col_q <= '0; rd_q <= '0; tcnt <= '0;
      ref_cnt <= '0; rfsh_stb <= 1'b0; rfsh_row <= '0;
      cyc_done <= 1'b0; cyc_kind <= '0; proto_err <= 1'b0;
    end else begin
      rfsh_stb <= 1'b0;
      cyc_done <= 1'b0;
      if (ras_fall) begin
        in_cyc   <= 1'b1;
        row_q    <= c_addr;
        cas_seen <= 1'b0;
        tcnt     <= '0;
        acc_kind <= '0;
        refr     <= ~c_cas & c_we;
        hid      <= ~c_cas & c_we & hold_rd;
        err_cyc  <= start_err;
        if (~c_cas & c_we) begin
          rfsh_stb <= 1'b1;
          rfsh_row <= ref_cnt;
          ref_cnt  <= ref_cnt + 1'b1;
        end
      end
      if (in_cyc & refr & ~self_ref & ~ras_rise) begin
        if (tcnt == CNT_W'(SR_TICKS - 1)) self_ref <= 1'b1;
        else tcnt <= tcnt + 1'b1;
      end
      if (cas_fall & acc) begin
        cas_seen <= 1'b1;
        col_q    <= c_addr[ACOL_W-1:0];
        acc_kind <= c_we ? 3'd1 : 3'd2;
        rd_vld   <= c_we;
      end
      if (rd_ev) rd_q <= mem[aidx];
      if (dw_ev) acc_kind <= 3'd3;
      if (refr_err) err_cyc <= 1'b1;
      if (start_err | refr_err) proto_err <= 1'b1;
      if (cas_rise) begin
        rd_vld  <= 1'b0;
        hold_rd <= 1'b0;
      end
      if (ras_rise) begin
        in_cyc   <= 1'b0;
        self_ref <= 1'b0;
        cyc_done <= 1'b1;
        hold_rd  <= ~c_cas & rd_vld;
        cyc_kind <= err_cyc  ? 3'd0 :
                    self_ref ? 3'd7 :
                    refr     ? (hid ? 3'd6 : 3'd5) :
                    cas_seen ? acc_kind : 3'd4;
        if (~refr & ~err_cyc & ~cas_seen) begin
          rfsh_stb <= 1'b1;
          rfsh_row <= row_q;
        end
      end
    end

  assign dq_oe  = rd_vld & ~c_cas & ~c_oe;
  assign dq_out = dq_oe ? rd_q : '0;

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cnt != $past(ref_cnt)) |-> (ref_cnt == $past(ref_cnt) + 1'b1));
  a_r8_self_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref |-> (in_cyc && refr));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err);
  a_r3_early_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ew_ev |=> !dq_oe);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);
  a_r9_no_write_in_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cyc || refr) |-> !wen);
endmodule

// File: tb/dram_strobe_ctl_tb_top.sv
module dram_strobe_ctl_tb_top;
  localparam int AW = 11, DW = 4, SRT = 40;
  logic clk = 0, rst_n = 0;
  logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, rfsh_stb, self_ref, cyc_done, proto_err;
  logic [AW-1:0] ref_cnt, rfsh_row;
  logic [2:0] cyc_kind;
  int errs = 0, chks = 0, stb_cnt = 0;
  int last_row = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dram_strobe_ctl #(.ADDR_W(AW), .DQ_W(DW), .AROW_W(2), .ACOL_W(2), .SR_TICKS(SRT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ref_cnt(ref_cnt),
    .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row), .self_ref(self_ref), .cyc_done(cyc_done),
    .cyc_kind(cyc_kind), .proto_err(proto_err));

  always @(negedge clk)
    if (rfsh_stb) begin
      last_row = int'(rfsh_row);
      stb_cnt++;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle;
    repeat (5) @(posedge clk);
    #5;
  endtask

  function automatic int pat(input int r, input int c);
    return (r * 5 + c * 3 + 1) % 16;
  endfunction

  task automatic cbr;
    cas_n = 0; settle; ras_n = 0; settle; ras_n = 1; settle; cas_n = 1; settle;
  endtask

  task automatic do_reset;
    rst_n = 0; settle; rst_n = 1; settle;
  endtask

  initial begin
    int c0, s0;
    do_reset;
    chk(dq_oe == 0 && proto_err == 0 && self_ref == 0, "R1 idle flags", {dq_oe, proto_err, self_ref}, 0);
    chk(ref_cnt == 0 && cyc_kind == 0, "R1 counter/kind", int'(ref_cnt) + int'(cyc_kind), 0);

    for (int i = 0; i < 2047; i++) cbr;
    chk(ref_cnt == 2047, "R6 count after 2047", int'(ref_cnt), 2047);
    chk(last_row == 2046, "R6 last row", last_row, 2046);
    chk(cyc_kind == 5, "R6 kind", int'(cyc_kind), 5);
    cbr;
    chk(ref_cnt == 0, "R11 wrap", int'(ref_cnt), 0);
    chk(last_row == 2047, "R11 top row", last_row, 2047);

    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        addr = AW'(r | (r << 4)); settle; ras_n = 0; settle;
        we_n = 0; addr = AW'(c | 8); dq_in = DW'(pat(r, c)); oe_n = 0; settle;
        cas_n = 0; settle;
        chk(dq_oe == 0, "R3 early write quiet", int'(dq_oe), 0);
        cas_n = 1; we_n = 1; settle; ras_n = 1; oe_n = 1; settle;
        chk(cyc_kind == 2, "R3 kind", int'(cyc_kind), 2);
      end

    for (int r = 0; r < 4; r++) begin
      addr = AW'(r); settle; ras_n = 0; oe_n = 0; settle;
      for (int c = 0; c < 4; c++) begin
        addr = AW'(c); settle; cas_n = 0; settle;
        chk(dq_oe == 1 && int'(dq_out) == pat(r, c), "R12 page read data", int'(dq_out), pat(r, c));
        cas_n = 1; settle;
        chk(dq_oe == 0, "R10 cas high off", int'(dq_oe), 0);
      end
      ras_n = 1; oe_n = 1; settle;
      chk(cyc_kind == 1, "R2 read kind", int'(cyc_kind), 1);
    end

    addr = 3; settle; ras_n = 0; settle; addr = 1; settle; cas_n = 0; settle;
    chk(dq_oe == 0, "R10 oe high off", int'(dq_oe), 0);
    oe_n = 0; settle;
    chk(dq_oe == 1 && int'(dq_out) == pat(3, 1), "R2 oe low drives", int'(dq_out), pat(3, 1));
    oe_n = 1; settle;
    chk(dq_oe == 0, "R10 oe raised", int'(dq_oe), 0);
    cas_n = 1; settle; ras_n = 1; settle;

    addr = 1; settle; ras_n = 0; settle; addr = 2; oe_n = 0; settle; cas_n = 0; settle;
    chk(dq_oe == 1 && int'(dq_out) == pat(1, 2), "R4 old data first", int'(dq_out), pat(1, 2));
    oe_n = 1; dq_in = 4'hA; settle; we_n = 0; settle;
    cas_n = 1; we_n = 1; settle; ras_n = 1; settle;
    chk(cyc_kind == 3, "R4 kind", int'(cyc_kind), 3);
    addr = 1; settle; ras_n = 0; settle; addr = 2; oe_n = 0; settle; cas_n = 0; settle;
    chk(int'(dq_out) == 10, "R4 new data stored", int'(dq_out), 10);
    cas_n = 1; oe_n = 1; settle; ras_n = 1; settle;

    c0 = int'(ref_cnt); s0 = stb_cnt;
    addr = 11'h2A5; settle; ras_n = 0; settle; ras_n = 1; settle;
    chk(last_row == 'h2A5, "R5 row", last_row, 'h2A5);
    chk(int'(ref_cnt) == c0 && stb_cnt == s0 + 1, "R5 counter kept", int'(ref_cnt), c0);
    chk(cyc_kind == 4, "R5 kind", int'(cyc_kind), 4);

    cas_n = 0; settle; ras_n = 0; settle;
    chk(self_ref == 0, "R8 short cycle no self", int'(self_ref), 0);
    ras_n = 1; settle; cas_n = 1; settle;
    chk(int'(ref_cnt) == c0 + 1 && last_row == c0, "R6 cbr row", last_row, c0);

    c0 = int'(ref_cnt);
    addr = 2; settle; ras_n = 0; settle; addr = 3; oe_n = 0; settle; cas_n = 0; settle;
    ras_n = 1; settle;
    chk(cyc_kind == 1, "R2 kind before hidden", int'(cyc_kind), 1);
    ras_n = 0; settle;
    chk(dq_oe == 1 && int'(dq_out) == pat(2, 3), "R7 data held", int'(dq_out), pat(2, 3));
    ras_n = 1; settle;
    chk(cyc_kind == 6, "R7 kind", int'(cyc_kind), 6);
    chk(int'(ref_cnt) == c0 + 1 && last_row == c0, "R7 refresh row", last_row, c0);
    cas_n = 1; oe_n = 1; settle;
    chk(dq_oe == 0, "R10 after hidden", int'(dq_oe), 0);

    c0 = int'(ref_cnt);
    cas_n = 0; settle; ras_n = 0; repeat (SRT + 10) @(posedge clk); #5;
    chk(self_ref == 1, "R8 self entered", int'(self_ref), 1);
    ras_n = 1; settle;
    chk(self_ref == 0, "R8 self exit", int'(self_ref), 0);
    chk(cyc_kind == 7, "R8 kind", int'(cyc_kind), 7);
    chk(int'(ref_cnt) == c0 + 1, "R8 one row", int'(ref_cnt), c0 + 1);
    cas_n = 1; settle;

    c0 = int'(ref_cnt);
    cas_n = 0; we_n = 0; settle; ras_n = 0; settle;
    chk(proto_err == 1, "R9 we low refresh", int'(proto_err), 1);
    ras_n = 1; settle; cas_n = 1; we_n = 1; settle;
    chk(int'(ref_cnt) == c0 && cyc_kind == 0, "R9 no advance", int'(ref_cnt), c0);
    cbr;
    chk(proto_err == 1, "R9 sticky", int'(proto_err), 1);

    do_reset;
    chk(proto_err == 0 && ref_cnt == 0, "R1 reset clears", int'(proto_err) + int'(ref_cnt), 0);
    cas_n = 0; settle; ras_n = 0; settle; cas_n = 1; settle;
    we_n = 0; addr = 0; dq_in = 5; settle; cas_n = 0; settle;
    chk(proto_err == 1, "R9 cas refall", int'(proto_err), 1);
    cas_n = 1; we_n = 1; settle; ras_n = 1; settle;
    chk(cyc_kind == 0 && ref_cnt == 1, "R9 refall kind", int'(cyc_kind), 0);
    addr = 0; settle; ras_n = 0; settle; oe_n = 0; settle; cas_n = 0; settle;
    chk(int'(dq_out) == pat(0, 0), "R9 array unchanged", int'(dq_out), pat(0, 0));
    cas_n = 1; oe_n = 1; settle; ras_n = 1; settle;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; chks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule